// File: doc/BRIEF.md
# CMI Line Decoder with Loss-of-Signal Qualifier

This receive-side block turns a recovered CMI line stream at the 155.52 Mbit/s STM-1 electrical rate into NRZ binary data. Each unit interval arrives as a strobe together with the two half-bit samples taken by the clock-recovery stage. A binary one is sent as two equal halves, and the level alternates from one binary one to the next. A binary zero is sent as a low half followed by a high half. The block reconstructs each bit and reports line-code violations as single-cycle pulses.

A digital loss-of-signal qualifier sits alongside the decoder. Two comparator flags from the analog front end feed it: one reports that the peak level is under the assert threshold, the other that it is over the higher clear threshold. The LOS flag only changes state once its condition has held for a configurable run of consecutive unit intervals. While LOS is up, the decoded data is forced to zero. The data-valid strobe keeps pulsing once per unit interval, so downstream logic keeps a steady timing reference. Monitor mode and local loopback each disable detection and hold LOS low.

The block also translates a two-bit reference-clock select code into a reference frequency mode.

Top module: `cmi_los_rx`

## Requirements
- R1: On each cycle with `uiStrobe` high, the pair (`halfA`,`halfB`) is decoded and the result appears one cycle later on `nrzData`, with `dataValid` high in that cycle. Equal halves (00 or 11) decode to 1. The pair 0 then 1 decodes to 0.
- R2: `codeViol` pulses high one cycle after a strobed pair that is either 1 then 0, or an equal pair at the same level as the previous equal pair. Zero pairs in between do not reset the alternation tracking.
- R3: After reset, `losFlag` is 1, and `nrzData`, `dataValid` and `codeViol` are 0.
- R4: When LOS is low, `losFlag` rises after the strobe that completes `LOS_UI` consecutive strobes with `belowAssert` high. A strobe with `belowAssert` low restarts the count.
- R5: When LOS is high, `losFlag` falls after the strobe that completes `LOS_UI` consecutive strobes with `aboveClear` high. A strobe with `aboveClear` low restarts the count.
- R6: A pair strobed while `losFlag` is high gives `nrzData` 0 and no `codeViol` pulse. `dataValid` still pulses for that pair.
- R7: When `monitorMode` or `loopbackMode` is high, `losFlag` is 0 from the next cycle and the persistence count is cleared. After both are released, assertion needs a full `LOS_UI` run.
- R8: `refClkMode` maps `refSelCode` as follows. Code 00 gives 0 (19.44 MHz). Code 10 gives 1 (77.76 MHz). Code 11 gives 2 (155.52 MHz). Reserved code 01 gives 0.
- R9: In a cycle following one with `uiStrobe` low, `dataValid` and `codeViol` are 0, and `nrzData` and `losFlag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uiStrobe | input | 1 | One pulse per recovered unit interval |
| halfA | input | 1 | First half-bit CMI sample |
| halfB | input | 1 | Second half-bit CMI sample |
| belowAssert | input | 1 | Comparator: peak level below LOS assert threshold |
| aboveClear | input | 1 | Comparator: peak level above LOS clear threshold |
| monitorMode | input | 1 | Receiver monitor mode, disables LOS |
| loopbackMode | input | 1 | Local loopback, disables LOS |
| refSelCode | input | 2 | Reference clock select code |
| nrzData | output | 1 | Decoded NRZ bit, squelched under LOS |
| dataValid | output | 1 | Pulses once per decoded unit interval |
| losFlag | output | 1 | Loss of signal |
| codeViol | output | 1 | CMI code-violation pulse |
| refClkMode | output | 2 | Decoded reference frequency mode |

## Verification
Suppose the alternation tracker holds the wrong level. Then a clean, correctly encoded stream raises `codeViol` on the very next binary one, so the fault shows within a few unit intervals of random data. An error in the persistence counter moves the LOS edge off the exact `LOS_UI`-th strobe. Dropouts placed just short of the interval also expose a counter that fails to restart, because LOS then toggles early. A squelch tied to the wrong LOS polarity shows up on the first strobe after LOS changes, either as ones leaking through during LOS or as data held at zero after it clears.

// File: rtl/cmi_los_pkg.sv
package cmi_los_pkg;

  typedef enum logic [1:0] {
    REF_19M44  = 2'd0,
    REF_77M76  = 2'd1,
    REF_155M52 = 2'd2
  } refClk_e;

  typedef struct packed {
    logic squelch;     // force decoded data to zero
    logic reportViol;  // allow violation pulses out
  } ctrlStrobes_t;

endpackage

// File: rtl/cmi_decode_dp.sv
module cmi_decode_dp
  import cmi_los_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uiStrobe,
  input  logic         halfA,
  input  logic         halfB,
  input  ctrlStrobes_t ctl,
  output logic         nrzData,
  output logic         dataValid,
  output logic         codeViol
);

  logic seenOne;
  logic lastOneLvl;
  logic pairEqual;
  logic badPair;
  logic badRepeat;

  always_comb begin
    pairEqual = (halfA == halfB);
    badPair   = halfA & ~halfB;
    badRepeat = pairEqual & seenOne & (lastOneLvl == halfA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzData    <= 1'b0;
      dataValid  <= 1'b0;
      codeViol   <= 1'b0;
      seenOne    <= 1'b0;
      lastOneLvl <= 1'b0;
    end else begin
      dataValid <= uiStrobe;
      codeViol  <= uiStrobe & (badPair | badRepeat) & ctl.reportViol;
      if (uiStrobe) begin
        nrzData <= pairEqual & ~ctl.squelch;
        if (pairEqual) begin
          seenOne    <= 1'b1;
          lastOneLvl <= halfA;
        end
      end
    end
  end

  // R6: squelched pair never leaks data or a violation
  p_squelch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uiStrobe && ctl.squelch) |=> (!nrzData && !codeViol));

  // R9: output bit holds between strobes
  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !uiStrobe |=> ($stable(nrzData) && !codeViol));

  // R2: a 1-then-0 half pair is always reported when reporting is enabled
  p_bad_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uiStrobe && halfA && !halfB && ctl.reportViol) |=> codeViol);

endmodule

// File: rtl/cmi_los_ctrl.sv
module cmi_los_ctrl
  import cmi_los_pkg::*;
#(
  parameter int LOS_UI = 110
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uiStrobe,
  input  logic         belowAssert,
  input  logic         aboveClear,
  input  logic         monitorMode,
  input  logic         loopbackMode,
  input  logic [1:0]   refSelCode,
  output logic         losFlag,
  output refClk_e      refClkMode,
  output ctrlStrobes_t ctl
);

  localparam int CNT_W = (LOS_UI > 1) ? $clog2(LOS_UI) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOS_UI - 1);

  logic [CNT_W-1:0] runCnt;
  logic             detectOff;
  logic             condMet;

  always_comb begin
    detectOff = monitorMode | loopbackMode;
    condMet   = losFlag ? aboveClear : belowAssert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      losFlag <= 1'b1;
      runCnt  <= '0;
    end else if (detectOff) begin
      losFlag <= 1'b0;
      runCnt  <= '0;
    end else if (uiStrobe) begin
      if (!condMet) begin
        runCnt <= '0;
      end else if (runCnt == CNT_LAST) begin
        runCnt  <= '0;
        losFlag <= ~losFlag;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (refSelCode)
      2'b10:   refClkMode = REF_77M76;
      2'b11:   refClkMode = REF_155M52;
      default: refClkMode = REF_19M44;
    endcase
  end

  always_comb begin
    ctl.squelch    = losFlag;
    ctl.reportViol = ~losFlag;
  end

  // R5/R4: persistence counter stays inside its interval
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    runCnt <= CNT_LAST);

  // R7: test modes force LOS low on the next cycle
  p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    detectOff |=> !losFlag);

  // R9: LOS only moves on a strobe unless detection is being disabled
  p_los_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!uiStrobe && !detectOff) |=> $stable(losFlag));

  // R4: LOS cannot rise from a strobe without the below flag
  p_rise_needs_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!losFlag && uiStrobe && !belowAssert) |=> !losFlag);

endmodule

// File: rtl/cmi_los_rx.sv
module cmi_los_rx
  import cmi_los_pkg::*;
#(
  parameter int LOS_UI = 110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uiStrobe,
  input  logic       halfA,
  input  logic       halfB,
  input  logic       belowAssert,
  input  logic       aboveClear,
  input  logic       monitorMode,
  input  logic       loopbackMode,
  input  logic [1:0] refSelCode,
  output logic       nrzData,
  output logic       dataValid,
  output logic       losFlag,
  output logic       codeViol,
  output logic [1:0] refClkMode
);

  ctrlStrobes_t ctl;
  refClk_e      refMode;

  cmi_los_ctrl #(.LOS_UI(LOS_UI)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .uiStrobe     (uiStrobe),
    .belowAssert  (belowAssert),
    .aboveClear   (aboveClear),
    .monitorMode  (monitorMode),
    .loopbackMode (loopbackMode),
    .refSelCode   (refSelCode),
    .losFlag      (losFlag),
    .refClkMode   (refMode),
    .ctl          (ctl)
  );

  cmi_decode_dp dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .uiStrobe  (uiStrobe),
    .halfA     (halfA),
    .halfB     (halfB),
    .ctl       (ctl),
    .nrzData   (nrzData),
    .dataValid (dataValid),
    .codeViol  (codeViol)
  );

  assign refClkMode = refMode;

endmodule

// File: tb/cmi_los_rx_tb.sv
module cmi_los_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LOS_UI     = 110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uiStrobe = 1'b0;
  logic       halfA = 1'b0;
  logic       halfB = 1'b1;
  logic       belowAssert = 1'b0;
  logic       aboveClear = 1'b0;
  logic       monitorMode = 1'b0;
  logic       loopbackMode = 1'b0;
  logic [1:0] refSelCode = 2'b00;
  logic       nrzData, dataValid, losFlag, codeViol;
  logic [1:0] refClkMode;

  int  testsRun = 0;
  int  testsFailed = 0;
  logic encLvl = 1'b0;  // level of the next binary one

  always #(CLK_PERIOD/2) clk = ~clk;

  cmi_los_rx #(.LOS_UI(LOS_UI)) dut_i (
    .clk(clk), .rst_n(rst_n), .uiStrobe(uiStrobe), .halfA(halfA), .halfB(halfB),
    .belowAssert(belowAssert), .aboveClear(aboveClear), .monitorMode(monitorMode),
    .loopbackMode(loopbackMode), .refSelCode(refSelCode), .nrzData(nrzData),
    .dataValid(dataValid), .losFlag(losFlag), .codeViol(codeViol),
    .refClkMode(refClkMode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one strobed UI carrying raw halves; called at a negedge, returns at the next
  task automatic rawUi(input logic a, input logic b, input logic below, input logic above);
    uiStrobe = 1'b1; halfA = a; halfB = b; belowAssert = below; aboveClear = above;
    @(negedge clk);
    uiStrobe = 1'b0;
  endtask

  // correctly encoded bit
  task automatic encUi(input logic bitV, input logic below, input logic above);
    if (bitV) begin
      rawUi(encLvl, encLvl, below, above);
      encLvl = ~encLvl;
    end else begin
      rawUi(1'b0, 1'b1, below, above);
    end
  endtask

  task automatic testReset();
    chk("R3", "losFlag", losFlag, 1);
    chk("R3", "nrzData", nrzData, 0);
    chk("R3", "dataValid", dataValid, 0);
    chk("R3", "codeViol", codeViol, 0);
  endtask

  task automatic testRefSel();
    refSelCode = 2'b00; #1; chk("R8", "code00", refClkMode, 0);
    refSelCode = 2'b10; #1; chk("R8", "code10", refClkMode, 1);
    refSelCode = 2'b11; #1; chk("R8", "code11", refClkMode, 2);
    refSelCode = 2'b01; #1; chk("R8", "code01", refClkMode, 0);
    @(negedge clk);
  endtask

  task automatic testClear();
    // short run then one dropout: LOS stays, data squelched
    for (int i = 0; i < LOS_UI - 10; i++) begin
      encUi(1'b1, 1'b0, 1'b1);
      chk("R6", "squelched bit", nrzData, 0);
      chk("R6", "valid under LOS", dataValid, 1);
    end
    encUi(1'b1, 1'b0, 1'b0);
    chk("R5", "LOS after dropout", losFlag, 1);
    for (int i = 1; i <= LOS_UI; i++) begin
      encUi(1'b1, 1'b0, 1'b1);
      chk("R5", "LOS during clear run", losFlag, (i < LOS_UI) ? 1 : 0);
    end
    encUi(1'b1, 1'b0, 1'b1);
    chk("R6", "data passes after clear", nrzData, 1);
  endtask

  task automatic testDecode();
    for (int i = 0; i < 300; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      encUi(b, 1'b0, 1'b1);
      chk("R1", "decoded bit", nrzData, b);
      chk("R1", "dataValid", dataValid, 1);
      chk("R2", "no violation on clean data", codeViol, 0);
    end
  endtask

  task automatic testViolations();
    rawUi(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2", "10 pair viol", codeViol, 1);
    chk("R1", "10 pair data", nrzData, 0);
    encUi(1'b1, 1'b0, 1'b1);
    chk("R2", "good one after 10", codeViol, 0);
    encUi(1'b0, 1'b0, 1'b1);
    rawUi(~encLvl, ~encLvl, 1'b0, 1'b1);  // repeats the previous level
    chk("R2", "repeated level viol", codeViol, 1);
    chk("R1", "repeated level data", nrzData, 1);
    encUi(1'b1, 1'b0, 1'b1);
    chk("R2", "recovered alternation", codeViol, 0);
  endtask

  task automatic testGap();
    encUi(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9", "valid low in gap", dataValid, 0);
    chk("R9", "data held in gap", nrzData, 1);
    chk("R9", "LOS held in gap", losFlag, 0);
    chk("R9", "viol low in gap", codeViol, 0);
  endtask

  task automatic testAssert();
    for (int i = 0; i < LOS_UI - 5; i++) encUi(1'b0, 1'b1, 1'b0);
    encUi(1'b0, 1'b0, 1'b0);
    chk("R4", "no LOS after dropout", losFlag, 0);
    for (int i = 1; i <= LOS_UI; i++) begin
      encUi(1'b1, 1'b1, 1'b0);
      chk("R4", "LOS during assert run", losFlag, (i < LOS_UI) ? 0 : 1);
    end
    encUi(1'b1, 1'b1, 1'b0);
    chk("R6", "ones squelched", nrzData, 0);
    chk("R6", "valid continues", dataValid, 1);
    rawUi(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6", "viol suppressed", codeViol, 0);
  endtask

  task automatic testModes();
    monitorMode = 1'b1;
    @(negedge clk);
    chk("R7", "monitor forces off", losFlag, 0);
    for (int i = 0; i < LOS_UI + 5; i++) encUi(1'b1, 1'b1, 1'b0);
    chk("R7", "monitor holds off", losFlag, 0);
    chk("R7", "data in monitor", nrzData, 1);
    monitorMode = 1'b0; loopbackMode = 1'b1;
    for (int i = 0; i < LOS_UI + 5; i++) encUi(1'b0, 1'b1, 1'b0);
    chk("R7", "loopback holds off", losFlag, 0);
    loopbackMode = 1'b0;
    for (int i = 1; i <= LOS_UI; i++) begin
      encUi(1'b0, 1'b1, 1'b0);
      if (i >= LOS_UI - 1)
        chk("R7", "full run after release", losFlag, (i < LOS_UI) ? 0 : 1);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testRefSel();
    testClear();
    testDecode();
    testViolations();
    testGap();
    testAssert();
    testModes();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule